// File: doc/BRIEF.md
# Precise Exception Completion Sequencer

This block takes exceptions precisely for a small in-order core. It looks at the entry at the head of the completion queue and takes an exception only when that entry has executed, carries an exception flag, and exceptions are enabled. Because every older instruction has already left the queue by then, all older work is complete. A head entry that finished cleanly retires at once. A faulting head instead starts a fixed sequence of phases:

- a flush phase, which cancels every younger entry;
- a queue-restore phase;
- a single save cycle, which redirects fetch to the handler vector and, at its closing edge, captures the return address and the status word;
- a wait for the fetch unit to report that the first handler instruction is ready. Handler dispatch is enabled only then.

While the sequence runs, a busy output stalls ordinary dispatch and further exception flags are ignored. The handler vector is a fixed base plus the 4-bit cause code of the faulting entry, shifted left by a parameter. The saved return address is the address of the faulting instruction itself, so that instruction runs again after the handler returns. A return-from-exception pulse reloads the status word from the saved copy and redirects fetch to the saved address.

Top module: `precExcSeq`

## Requirements
- R1: After reset: `busy`, `flush`, `qRestore`, `redirectValid`, `handlerGo` and `retire` are low, `srr0` and `srr1` are 0, and `statusWord` equals RESET_STATUS (default 0x0000C000).
- R2: When the sequencer is idle and the head entry is valid, done and not flagged, `retire` is high in that same cycle and no flush follows.
- R3: An exception is recognized at a clock edge only if all of the following hold at that edge: the sequencer is idle, the head is valid, done and flagged, and status bit EE_BIT (15) is 1. A flagged head that is not done starts nothing, and `busy` stays low.
- R4: `flush` is high for exactly FLUSH_CYC cycles (default 1), beginning in the cycle after recognition.
- R5: `qRestore` is high for exactly RESTORE_CYC cycles (default 2, never fewer than 2), beginning in the cycle after the last flush cycle. This puts the end of the restore at least 3 cycles after recognition.
- R6: `redirectValid` is high for a single cycle, the one after the last restore cycle, with `redirectPc` = VEC_BASE + (cause << CAUSE_SHIFT). The defaults are VEC_BASE 0xFFF00000 and CAUSE_SHIFT 8.
- R7: At the edge that ends the redirect cycle, three registers update. `srr0` takes the faulting entry's PC. `srr1` takes the prior status word. `statusWord` clears bit 15 (exception enable) and bit 14 (1 = user mode, 0 = privileged).
- R8: `handlerGo` is high in the first cycle after the redirect cycle in which `fetchReady` is high, and in no other cycle.
- R9: While status bit 15 is 0, a flagged head that is done causes no flush and no retire.
- R10: `busy` is high from the cycle after recognition through the `handlerGo` cycle and low in the next cycle. `retire` is low whenever `busy` is high.
- R11: When idle and no exception is recognized, a high `rfi` raises `redirectValid` in the same cycle with `redirectPc` = `srr0`. At the next edge `statusWord` takes the value of `srr1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| headValid | input | 1 | Head queue entry holds an instruction |
| headDone | input | 1 | Head entry has finished executing |
| headExc | input | 1 | Head entry raised an exception |
| headCause | input | 4 | Cause code of the head entry |
| headPc | input | 32 | Address of the head entry |
| fetchReady | input | 1 | First handler instruction is available |
| rfi | input | 1 | Return-from-exception request |
| retire | output | 1 | Head entry retires this cycle |
| flush | output | 1 | Cancel all younger queue entries |
| qRestore | output | 1 | Queue state restore in progress |
| redirectValid | output | 1 | Fetch redirect request |
| redirectPc | output | 32 | Fetch redirect target |
| busy | output | 1 | Stall ordinary dispatch |
| handlerGo | output | 1 | Handler instructions may dispatch |
| srr0 | output | 32 | Saved return address |
| srr1 | output | 32 | Saved status word |
| statusWord | output | 32 | Current status word |

## Verification
If recognition happens at the edge that closes cycle 0, the outputs fall due as follows. `flush` occupies cycles 1 to F, `qRestore` the next R cycles, and the redirect cycle F+R+1. The saved registers and the cleared status bits are visible from cycle F+R+2. `handlerGo` appears in cycle F+R+2+d, where d is the number of cycles the bench holds `fetchReady` low, and `busy` is low one cycle later. The combinational outputs `retire`, and the redirect that `rfi` triggers, are due in the cycle of their stimulus. The status reload from `rfi` is due one cycle later. The bench drives inputs just after the rising edge and samples on the falling edge. For every one of the 16 causes and four fetch delays, it compares each output with a cycle-indexed expectation.

// File: rtl/excSeqPkg.sv
package excSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_RESTORE,
    ST_SAVE,
    ST_WAITF
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchFault;  // capture head PC and cause
    logic saveCtx;     // write save registers, drop EE and user bits
    logic rfiLoad;     // reload status from saved copy
    logic selHandler;  // redirect target is handler vector
  } seqStrobe_t;

endpackage

// File: rtl/excSeqCtrl.sv
module excSeqCtrl
  import excSeqPkg::*;
#(
  parameter int FLUSH_CYC   = 1,
  parameter int RESTORE_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       headValid,
  input  logic       headDone,
  input  logic       headExc,
  input  logic       fetchReady,
  input  logic       rfi,
  input  logic       excEnabled,
  output seqStrobe_t strb,
  output logic       retire,
  output logic       flush,
  output logic       qRestore,
  output logic       redirectValid,
  output logic       busy,
  output logic       handlerGo
);
  localparam int MAX_CYC = (FLUSH_CYC > RESTORE_CYC) ? FLUSH_CYC : RESTORE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  seqState_t   st;
  logic [CNT_W-1:0] cnt;
  logic idle, recog, rfiTake;

  assign idle    = (st == ST_IDLE);
  assign recog   = idle && headValid && headDone && headExc && excEnabled;
  assign rfiTake = idle && rfi && !recog;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (recog) begin
          st  <= ST_FLUSH;
          cnt <= CNT_W'(FLUSH_CYC - 1);
        end
        ST_FLUSH: if (cnt == '0) begin
          st  <= ST_RESTORE;
          cnt <= CNT_W'(RESTORE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_RESTORE: if (cnt == '0) st <= ST_SAVE;
                    else cnt <= cnt - 1'b1;
        ST_SAVE:  st <= ST_WAITF;
        ST_WAITF: if (fetchReady) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchFault = recog;
    strb.saveCtx    = (st == ST_SAVE);
    strb.rfiLoad    = rfiTake;
    strb.selHandler = (st == ST_SAVE);
  end

  assign retire        = idle && headValid && headDone && !headExc;
  assign flush         = (st == ST_FLUSH);
  assign qRestore      = (st == ST_RESTORE);
  assign redirectValid = (st == ST_SAVE) || rfiTake;
  assign busy          = !idle;
  assign handlerGo     = (st == ST_WAITF) && fetchReady;
endmodule

// File: rtl/excSeqData.sv
module excSeqData
  import excSeqPkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          CAUSE_W      = 4,
  parameter int          CAUSE_SHIFT  = 8,
  parameter int          EE_BIT       = 15,
  parameter int          USER_BIT     = 14,
  parameter logic [31:0] VEC_BASE     = 32'hFFF0_0000,
  parameter logic [31:0] RESET_STATUS = 32'h0000_C000
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic [XLEN-1:0]    headPc,
  input  logic [CAUSE_W-1:0] headCause,
  output logic [XLEN-1:0]    redirectPc,
  output logic [XLEN-1:0]    srr0,
  output logic [XLEN-1:0]    srr1,
  output logic [XLEN-1:0]    statusWord,
  output logic               excEnabled
);
  localparam logic [XLEN-1:0] CLR_MASK = ~((XLEN'(1) << EE_BIT) | (XLEN'(1) << USER_BIT));

  logic [XLEN-1:0]    faultPc;
  logic [CAUSE_W-1:0] faultCause;
  logic [XLEN-1:0]    handlerPc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultPc    <= '0;
      faultCause <= '0;
      srr0       <= '0;
      srr1       <= '0;
      statusWord <= XLEN'(RESET_STATUS);
    end else begin
      if (strb.latchFault) begin
        faultPc    <= headPc;
        faultCause <= headCause;
      end
      if (strb.saveCtx) begin
        srr0       <= faultPc;
        srr1       <= statusWord;
        statusWord <= statusWord & CLR_MASK;
      end else if (strb.rfiLoad) begin
        statusWord <= srr1;
      end
    end
  end

  assign handlerPc  = XLEN'(VEC_BASE) + (XLEN'(faultCause) << CAUSE_SHIFT);
  assign redirectPc = strb.selHandler ? handlerPc : srr0;
  assign excEnabled = statusWord[EE_BIT];
endmodule

// File: rtl/precExcSeq.sv
module precExcSeq
  import excSeqPkg::*;
#(
  parameter int          XLEN         = 32,
  parameter int          CAUSE_W      = 4,
  parameter int          CAUSE_SHIFT  = 8,
  parameter int          EE_BIT       = 15,
  parameter int          USER_BIT     = 14,
  parameter int          FLUSH_CYC    = 1,
  parameter int          RESTORE_CYC  = 2,
  parameter logic [31:0] VEC_BASE     = 32'hFFF0_0000,
  parameter logic [31:0] RESET_STATUS = 32'h0000_C000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               headValid,
  input  logic               headDone,
  input  logic               headExc,
  input  logic [CAUSE_W-1:0] headCause,
  input  logic [XLEN-1:0]    headPc,
  input  logic               fetchReady,
  input  logic               rfi,
  output logic               retire,
  output logic               flush,
  output logic               qRestore,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               busy,
  output logic               handlerGo,
  output logic [XLEN-1:0]    srr0,
  output logic [XLEN-1:0]    srr1,
  output logic [XLEN-1:0]    statusWord
);
  seqStrobe_t strb;
  logic       excEnabled;

  excSeqCtrl #(
    .FLUSH_CYC  (FLUSH_CYC),
    .RESTORE_CYC(RESTORE_CYC)
  ) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .headValid    (headValid),
    .headDone     (headDone),
    .headExc      (headExc),
    .fetchReady   (fetchReady),
    .rfi          (rfi),
    .excEnabled   (excEnabled),
    .strb         (strb),
    .retire       (retire),
    .flush        (flush),
    .qRestore     (qRestore),
    .redirectValid(redirectValid),
    .busy         (busy),
    .handlerGo    (handlerGo)
  );

  excSeqData #(
    .XLEN        (XLEN),
    .CAUSE_W     (CAUSE_W),
    .CAUSE_SHIFT (CAUSE_SHIFT),
    .EE_BIT      (EE_BIT),
    .USER_BIT    (USER_BIT),
    .VEC_BASE    (VEC_BASE),
    .RESET_STATUS(RESET_STATUS)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .headPc    (headPc),
    .headCause (headCause),
    .redirectPc(redirectPc),
    .srr0      (srr0),
    .srr1      (srr1),
    .statusWord(statusWord),
    .excEnabled(excEnabled)
  );
endmodule

// File: rtl/excSeqChk.sv
module excSeqChk #(
  parameter int XLEN     = 32,
  parameter int EE_BIT   = 15,
  parameter int USER_BIT = 14
) (
  input logic            clk,
  input logic            rstN,
  input logic            headValid,
  input logic            headDone,
  input logic            headExc,
  input logic            retire,
  input logic            flush,
  input logic            qRestore,
  input logic            redirectValid,
  input logic            busy,
  input logic            handlerGo,
  input logic [XLEN-1:0] statusWord
);
  // R4
  flush_after_recog_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flush) |-> $past(headValid && headDone && headExc && !busy && statusWord[EE_BIT]));

  // R4
  flush_restore_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(flush && qRestore));

  // R5
  restore_min_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(qRestore) |=> qRestore);

  // R6
  redirect_after_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(qRestore) |-> (redirectValid && busy));

  // R7
  ctx_saved_chk: assert property (@(posedge clk) disable iff (!rstN)
    handlerGo |-> (!statusWord[EE_BIT] && !statusWord[USER_BIT]));

  // R10
  no_retire_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !retire);
endmodule

bind precExcSeq excSeqChk #(
  .XLEN    (XLEN),
  .EE_BIT  (EE_BIT),
  .USER_BIT(USER_BIT)
) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .headValid    (headValid),
  .headDone     (headDone),
  .headExc      (headExc),
  .retire       (retire),
  .flush        (flush),
  .qRestore     (qRestore),
  .redirectValid(redirectValid),
  .busy         (busy),
  .handlerGo    (handlerGo),
  .statusWord   (statusWord)
);

// File: tb/sim_precExcSeq.sv
`timescale 1ns/1ps
module sim_precExcSeq;
  localparam int F = 1;
  localparam int R = 2;
  localparam logic [31:0] VBASE = 32'hFFF0_0000;
  localparam logic [31:0] RST_ST = 32'h0000_C000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic headValid = 0, headDone = 0, headExc = 0, fetchReady = 0, rfi = 0;
  logic [3:0]  headCause = '0;
  logic [31:0] headPc = '0;
  logic retire, flush, qRestore, redirectValid, busy, handlerGo;
  logic [31:0] redirectPc, srr0, srr1, statusWord;

  int nTests = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  precExcSeq u0 (
    .clk(clk), .rstN(rstN), .headValid(headValid), .headDone(headDone),
    .headExc(headExc), .headCause(headCause), .headPc(headPc),
    .fetchReady(fetchReady), .rfi(rfi), .retire(retire), .flush(flush),
    .qRestore(qRestore), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .busy(busy), .handlerGo(handlerGo), .srr0(srr0), .srr1(srr1),
    .statusWord(statusWord)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drv();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    smp();
    // R1 reset state
    chk({31'b0, busy}, 0, "R1 busy");
    chk({31'b0, flush | qRestore | redirectValid | handlerGo | retire}, 0, "R1 strobes");
    chk(srr0, 0, "R1 srr0");
    chk(srr1, 0, "R1 srr1");
    chk(statusWord, RST_ST, "R1 status");

    // R2 clean retire
    drv(); headValid = 1; headDone = 1; headExc = 0;
    smp(); chk({31'b0, retire}, 1, "R2 retire");
    drv(); headValid = 0; headDone = 0;
    smp(); chk({31'b0, busy | flush}, 0, "R2 no flush");

    // R3 flagged but not done
    drv(); headValid = 1; headDone = 0; headExc = 1;
    smp(); chk({31'b0, retire}, 0, "R3 no retire undone");
    drv(); headValid = 0; headExc = 0;
    smp(); chk({31'b0, busy | flush}, 0, "R3 undone not taken");

    for (int c = 0; c < 16; c++) begin
      for (int d = 0; d < 4; d++) begin
        logic [31:0] pc;
        int last;
        pc = 32'h1000_0000 + 32'(c) * 32'h44 + 32'(d) * 4;
        last = F + R + 2 + d;
        drv();
        headValid = 1; headDone = 1; headExc = 1;
        headCause = 4'(c); headPc = pc; fetchReady = 0;
        smp(); chk({31'b0, busy}, 0, "R3 idle before recog");
        for (int j = 1; j <= last + 1; j++) begin
          drv();
          if (j == 2) headPc = ~pc; // later head changes must not leak in
          fetchReady = (j >= last);
          smp();
          chk({31'b0, flush}, {31'b0, (j <= F)}, "R4 flush");
          chk({31'b0, qRestore}, {31'b0, (j > F && j <= F + R)}, "R5 restore");
          chk({31'b0, redirectValid}, {31'b0, (j == F + R + 1)}, "R6 redirect");
          if (j == F + R + 1)
            chk(redirectPc, VBASE + (32'(c) << 8), "R6 vector");
          chk({31'b0, handlerGo}, {31'b0, (j == last)}, "R8 handlerGo");
          chk({31'b0, busy}, {31'b0, (j <= last)}, "R10 busy");
          chk({31'b0, retire}, 0, "R10 R9 no retire");
          if (j == F + R + 2) begin
            chk(srr0, pc, "R7 srr0");
            chk(srr1, RST_ST, "R7 srr1");
            chk(statusWord, RST_ST & ~32'h0000_C000, "R7 status");
          end
        end
        // R9 masked: head still flagged and done, one more idle cycle
        drv(); fetchReady = 0;
        smp(); chk({31'b0, busy | flush | retire}, 0, "R9 masked");
        // R11 return
        drv(); headValid = 0; headDone = 0; headExc = 0; rfi = 1;
        smp();
        chk({31'b0, redirectValid}, 1, "R11 redirect");
        chk(redirectPc, pc, "R11 target");
        drv(); rfi = 0;
        smp(); chk(statusWord, RST_ST, "R11 status restored");
        chk({31'b0, busy}, 0, "R11 idle");
      end
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule